// File: doc/BRIEF.md
# Walking-Pattern Word Memory Self-Test Engine

This block is a built-in test engine for a 16-bit word memory. On a start pulse it latches a size code. It then runs a fixed number of test cycles. Each cycle writes a walking-bit pattern into every word of the selected region and afterwards reads every word back and compares it with the word that was written. The pattern moves by one position on each new cycle, and at regular intervals it switches to its complement, so a fault that depends on the data pattern is exposed in at least one cycle.

Every mismatch becomes an error record: the byte address of the word, the word that was written and the word that came back. The record is offered on a valid/ready port. While the record waits, the engine holds all memory traffic. After an error the test goes on, so one run can report many faults. The index of the current cycle is visible on an output. A done flag rises when the last cycle finishes.

The memory side is a plain synchronous request port. A request is held until the memory accepts it. Read data is returned one clock after the read is accepted.

Top module: `mt_walk_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `done`, `mem_req` and `err_valid` are low and `cycle_num` is zero.
- R2: A `start` pulse seen while idle or done latches `size_sel` and begins a run. A `start` seen during a run is ignored and has no effect on the region tested.
- R3: A run covers (size_sel+1)·2^UNIT_LOG2 words. Word i sits at byte address 2·i, so every address is even, and the address is ADDR_W bits wide.
- R4: In cycle c, word i holds a value built from s = i + c. Bit number s mod 16 (s[3:0]) is set and all other bits are clear. When s[4] is 1, the whole word is inverted.
- R5: In each cycle, all words are written in ascending address order before any word is read. The reads then follow, also in ascending order.
- R6: A run has NUM_CYCLES cycles (33 by default). `cycle_num` shows the index of the cycle in progress, from 0 to NUM_CYCLES-1.
- R7: Read data is compared on the clock after the read is accepted. A mismatch raises `err_valid` with the word's byte address, the word written and the word read.
- R8: An error record stays on the port, unchanged, until `err_ready` is high. While `err_valid` is high, no memory request is issued.
- R9: Errors do not stop the run. When the last cycle ends, `done` rises and stays high, with `busy` low, until the next `start`.
- R10: A memory request keeps its address, direction and write data unchanged until `mem_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when idle or done |
| size_sel | input | SEL_W | Region size code, latched at start |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a write request, 0 for a read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the request in this cycle |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read is accepted |
| err_valid | output | 1 | Error record present |
| err_ready | input | 1 | Consumer takes the error record |
| err_addr | output | ADDR_W | Byte address of the failing word |
| err_wdata | output | DATA_W | Word that was written |
| err_rdata | output | DATA_W | Word that was read back |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| cycle_num | output | CYC_W | Index of the current test cycle |

## Verification
The bench builds the engine with UNIT_LOG2 = 2, so each size step adds four words and the largest region has 32 words. It also sets NUM_CYCLES to 5. With these values every size code and the last word of the largest region can be tested in a few thousand clocks. Because i + c reaches past 16, the runs also cross from walking ones into walking zeros. A memory model in the bench forces chosen bits of one word to a fixed value, places stalls on both handshakes, and checks the number, order and contents of the records against counts worked out from the pattern rule.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WRITE  = 3'd1,
    ST_READ   = 3'd2,
    ST_CHECK  = 3'd3,
    ST_REPORT = 3'd4,
    ST_DONE   = 3'd5
  } mt_state_e;

endpackage

// File: rtl/mt_pattern_gen.sv
module mt_pattern_gen #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 21,
  parameter int CYC_W  = 6
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [CYC_W-1:0]  cyc,
  output logic [DATA_W-1:0] word
);

  localparam int SH_W = $clog2(DATA_W);
  localparam int S_W  = IDX_W + 1;

  logic [S_W-1:0]    sum;
  logic [DATA_W-1:0] one_hot;

  // walk position and polarity both come from the sum of index and cycle
  always_comb begin
    sum     = {1'b0, idx} + S_W'(cyc);
    one_hot = DATA_W'(1) << sum[SH_W-1:0];
    word    = sum[SH_W] ? ~one_hot : one_hot;
  end

endmodule

// File: rtl/mt_index_ctr.sv
module mt_index_ctr #(
  parameter int SEL_W     = 3,
  parameter int UNIT_LOG2 = 18,
  localparam int IDX_W    = SEL_W + UNIT_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [SEL_W-1:0] size_sel,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  // last word of a region of (size_sel+1) units
  assign at_last = (idx_q == {size_sel, {UNIT_LOG2{1'b1}}});
  assign idx     = idx_q;

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (inc) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           idx_q <= '0;
    else if (clr || inc)  idx_q <= idx_d;
  end

endmodule

// File: rtl/mt_err_capture.sv
module mt_err_capture #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] rdata_in,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic valid_q;
  logic valid_d;

  always_comb begin
    valid_d = valid_q;
    if (load)                  valid_d = 1'b1;
    else if (valid_q && ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      wdata <= '0;
      rdata <= '0;
    end else if (load) begin
      addr  <= addr_in;
      wdata <= wdata_in;
      rdata <= rdata_in;
    end
  end

  assign valid = valid_q;

endmodule

// File: rtl/mt_walk_engine.sv
module mt_walk_engine #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int SEL_W      = 3,
  parameter int UNIT_LOG2  = 18,
  parameter int NUM_CYCLES = 33,
  localparam int CYC_W     = $clog2(NUM_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  size_sel,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              err_valid,
  input  logic              err_ready,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_wdata,
  output logic [DATA_W-1:0] err_rdata,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  cycle_num
);

  import mt_pkg::*;

  localparam int IDX_W = SEL_W + UNIT_LOG2;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(NUM_CYCLES - 1);

  mt_state_e        state_q, state_d;
  logic [SEL_W-1:0] size_q;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [IDX_W-1:0] idx;
  logic             at_last;
  logic [DATA_W-1:0] pat;
  logic             mismatch;
  logic             idx_clr, idx_inc, cyc_clr, cyc_inc, size_ld, cap_ld, advance;

  mt_index_ctr #(.SEL_W(SEL_W), .UNIT_LOG2(UNIT_LOG2)) idx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (idx_clr),
    .inc      (idx_inc),
    .size_sel (size_q),
    .idx      (idx),
    .at_last  (at_last)
  );

  mt_pattern_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CYC_W(CYC_W)) pat_i (
    .idx  (idx),
    .cyc  (cyc_q),
    .word (pat)
  );

  assign mem_req   = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = ADDR_W'({idx, 1'b0});
  assign mem_wdata = pat;
  assign mismatch  = (mem_rdata != pat);

  mt_err_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cap_ld),
    .addr_in  (mem_addr),
    .wdata_in (pat),
    .rdata_in (mem_rdata),
    .ready    (err_ready),
    .valid    (err_valid),
    .addr     (err_addr),
    .wdata    (err_wdata),
    .rdata    (err_rdata)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_clr = 1'b0;
    idx_inc = 1'b0;
    cyc_clr = 1'b0;
    cyc_inc = 1'b0;
    size_ld = 1'b0;
    cap_ld  = 1'b0;
    advance = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_WRITE;
          idx_clr = 1'b1;
          cyc_clr = 1'b1;
          size_ld = 1'b1;
        end
      end
      ST_WRITE: begin
        if (mem_ready) begin
          if (at_last) begin
            idx_clr = 1'b1;
            state_d = ST_READ;
          end else begin
            idx_inc = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (mem_ready) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (mismatch) begin
          cap_ld  = 1'b1;
          state_d = ST_REPORT;
        end else begin
          advance = 1'b1;
        end
      end
      ST_REPORT: begin
        if (err_ready) advance = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (advance) begin
      if (at_last) begin
        idx_clr = 1'b1;
        if (cyc_q == CYC_LAST) begin
          state_d = ST_DONE;
        end else begin
          cyc_inc = 1'b1;
          state_d = ST_WRITE;
        end
      end else begin
        idx_inc = 1'b1;
        state_d = ST_READ;
      end
    end
  end

  always_comb begin
    cyc_d = cyc_q;
    if (cyc_clr)      cyc_d = '0;
    else if (cyc_inc) cyc_d = cyc_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cyc_q <= '0;
    else if (cyc_clr || cyc_inc) cyc_q <= cyc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       size_q <= '0;
    else if (size_ld) size_q <= size_sel;
  end

  assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done      = (state_q == ST_DONE);
  assign cycle_num = cyc_q;

endmodule

// File: rtl/mt_walk_engine_chk.sv
module mt_walk_engine_chk #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int NUM_CYCLES = 33,
  parameter int CYC_W      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              err_valid,
  input logic              err_ready,
  input logic [ADDR_W-1:0] err_addr,
  input logic [DATA_W-1:0] err_wdata,
  input logic [DATA_W-1:0] err_rdata,
  input logic              busy,
  input logic              done,
  input logic [CYC_W-1:0]  cycle_num
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!mem_req && !err_valid && !done && !busy));

  p_addr_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  p_cycle_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cycle_num) < NUM_CYCLES);

  p_err_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_wdata != err_rdata));

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_ready) |=> (err_valid && $stable(err_addr)
                                   && $stable(err_wdata) && $stable(err_rdata)));

  p_report_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !mem_req);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req && !err_valid));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                 && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind mt_walk_engine mt_walk_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CYCLES(NUM_CYCLES), .CYC_W(CYC_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .err_valid (err_valid),
  .err_ready (err_ready),
  .err_addr  (err_addr),
  .err_wdata (err_wdata),
  .err_rdata (err_rdata),
  .busy      (busy),
  .done      (done),
  .cycle_num (cycle_num)
);

// File: tb/mt_walk_engine_tb_top.sv
module mt_walk_engine_tb_top;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 3;
  localparam int ULOG   = 2;
  localparam int NCYC   = 5;
  localparam int CYC_W  = $clog2(NCYC);
  localparam int NVEC   = 6;

  // {stall, size, fault word, stuck-one mask, keep mask}
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 8'd255, 16'h0000, 16'hFFFF},
    {1'b0, 3'd1, 8'd5,   16'h0001, 16'hFFFF},
    {1'b1, 3'd7, 8'd31,  16'h0000, 16'h7FFF},
    {1'b1, 3'd3, 8'd0,   16'h8000, 16'hFFFF},
    {1'b0, 3'd2, 8'd20,  16'hFFFF, 16'hFFFF},
    {1'b1, 3'd7, 8'd17,  16'h0000, 16'h0000}
  };

  logic clk, rst_n, start;
  logic [SEL_W-1:0]  size_sel;
  logic              mem_req, mem_we, mem_ready;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              err_valid, err_ready;
  logic [ADDR_W-1:0] err_addr;
  logic [DATA_W-1:0] err_wdata, err_rdata;
  logic              busy, done;
  logic [CYC_W-1:0]  cycle_num;

  mt_walk_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .UNIT_LOG2(ULOG), .NUM_CYCLES(NCYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .err_valid(err_valid), .err_ready(err_ready), .err_addr(err_addr),
    .err_wdata(err_wdata), .err_rdata(err_rdata),
    .busy(busy), .done(done), .cycle_num(cycle_num)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] bpat(input int i, input int c);
    int s;
    logic [15:0] w;
    s = i + c;
    w = 16'h0001 << (s % 16);
    if (((s / 16) % 2) == 1) w = ~w;
    return w;
  endfunction

  // bench memory with one faulty word on the read path
  logic [15:0] bmem [0:63];
  logic [7:0]  flt_idx;
  logic [15:0] flt_or, flt_and;
  logic        stall_en, err_hold;

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) bmem[mem_addr[6:1]] <= mem_wdata;
      else if ({2'b00, mem_addr[6:1]} == flt_idx)
        mem_rdata <= (bmem[mem_addr[6:1]] & flt_and) | flt_or;
      else
        mem_rdata <= bmem[mem_addr[6:1]];
    end
  end

  // handshake drivers and monitor
  int tick = 0;
  int cur_words;
  int wr_cnt, rd_cnt, order_bad, exp_idx, phase, cyc_seen, err_seen, rec_bad;

  always @(negedge clk) begin
    tick++;
    mem_ready = stall_en ? ((tick % 4) != 0) : 1'b1;
    err_ready = err_hold ? 1'b0 : (stall_en ? ((tick % 8) >= 3) : 1'b1);
    if (mem_req && mem_ready) begin
      if (mem_we !== (phase == 0)) order_bad++;
      if (mem_addr !== ADDR_W'(2 * exp_idx)) order_bad++;
      if (int'(cycle_num) != cyc_seen) order_bad++;
      if (mem_we) begin
        wr_cnt++;
        if (mem_wdata !== bpat(exp_idx, cyc_seen)) order_bad++;
      end else begin
        rd_cnt++;
      end
      if (exp_idx == cur_words - 1) begin
        exp_idx = 0;
        if (phase == 1) cyc_seen++;
        phase = 1 - phase;
      end else begin
        exp_idx++;
      end
    end
    if (err_valid && err_ready) begin
      err_seen++;
      if (err_addr !== ADDR_W'(2 * int'(flt_idx))) rec_bad++;
      if (err_wdata !== bpat(int'(flt_idx), int'(cycle_num))) rec_bad++;
      if (err_rdata !== ((err_wdata & flt_and) | flt_or)) rec_bad++;
    end
  end

  task automatic start_run(input logic [SEL_W-1:0] sz);
    @(negedge clk);
    cur_words = (int'(sz) + 1) << ULOG;
    wr_cnt = 0; rd_cnt = 0; order_bad = 0; exp_idx = 0; phase = 0;
    cyc_seen = 0; err_seen = 0; rec_bad = 0;
    size_sel = sz;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
    end
    if (!ok) check(1'b0, "watchdog R9", 0, 1);
  endtask

  function automatic int exp_errs(input int words, input int f, input logic [15:0] om, input logic [15:0] am);
    int n = 0;
    if (f >= words) return 0;
    for (int c = 0; c < NCYC; c++) begin
      logic [15:0] p;
      p = bpat(f, c);
      if (((p & am) | om) != p) n++;
    end
    return n;
  endfunction

  initial begin
    bit ok;
    int mem_bad;
    rst_n = 1'b0; start = 1'b0; size_sel = '0;
    flt_idx = 8'd255; flt_or = 16'h0; flt_and = 16'hFFFF;
    stall_en = 1'b0; err_hold = 1'b0;
    cur_words = 4; exp_idx = 0; phase = 0; cyc_seen = 0;
    wr_cnt = 0; rd_cnt = 0; order_bad = 0; err_seen = 0; rec_bad = 0;
    repeat (3) @(negedge clk);
    // R1: quiet in reset
    check(!busy && !done && !mem_req && !err_valid, "R1 outputs in reset",
          {busy, done, mem_req, err_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !mem_req && !err_valid && cycle_num == 0,
          "R1 outputs after reset", {busy, done, mem_req, err_valid, cycle_num}, 0);

    // table of runs
    for (int v = 0; v < NVEC; v++) begin
      logic [43:0] e;
      int nexp;
      e = VEC[v];
      stall_en = e[43];
      flt_idx  = e[39:32];
      flt_or   = e[31:16];
      flt_and  = e[15:0];
      start_run(e[42:40]);
      wait_done(ok);
      nexp = exp_errs(cur_words, int'(flt_idx), flt_or, flt_and);
      check(wr_cnt == cur_words * NCYC, "R3 R10 write count", wr_cnt, cur_words * NCYC);
      check(rd_cnt == cur_words * NCYC, "R3 read count", rd_cnt, cur_words * NCYC);
      check(order_bad == 0, "R4 R5 order/pattern", order_bad, 0);
      check(cyc_seen == NCYC, "R6 cycles run", cyc_seen, NCYC);
      check(err_seen == nexp, "R7 R9 error count", err_seen, nexp);
      check(rec_bad == 0, "R7 record fields", rec_bad, 0);
      mem_bad = 0;
      for (int k = 0; k < cur_words; k++)
        if (bmem[k] !== bpat(k, NCYC - 1)) mem_bad++;
      check(mem_bad == 0, "R4 final memory image", mem_bad, 0);
      check(done && !busy, "R9 done flag", {done, busy}, 2);
    end

    // R9: done persists
    repeat (6) @(negedge clk);
    check(done && !busy && !mem_req, "R9 done held", {done, busy, mem_req}, 4);

    // R2: start during run ignored
    stall_en = 1'b0; flt_idx = 8'd255; flt_or = 16'h0; flt_and = 16'hFFFF;
    start_run(3'd1);
    repeat (10) @(negedge clk);
    size_sel = 3'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check(wr_cnt == 8 * NCYC, "R2 start ignored while busy", wr_cnt, 8 * NCYC);

    // R8: record held while consumer not ready
    begin
      logic [ADDR_W-1:0] a0;
      logic [DATA_W-1:0] w0, r0;
      logic [CYC_W-1:0]  c0;
      flt_idx = 8'd1; flt_or = 16'h0; flt_and = 16'h0;
      err_hold = 1'b1;
      start_run(3'd0);
      ok = 1'b0;
      for (int k = 0; k < 500; k++) begin
        @(negedge clk);
        if (err_valid) begin ok = 1'b1; break; end
      end
      check(ok, "R7 error raised", ok, 1);
      a0 = err_addr; w0 = err_wdata; r0 = err_rdata; c0 = cycle_num;
      repeat (10) @(negedge clk);
      check(err_valid && !mem_req, "R8 stall while record pending",
            {err_valid, mem_req}, 2);
      check(err_addr == a0 && err_wdata == w0 && err_rdata == r0 && cycle_num == c0,
            "R8 record stable", err_wdata, w0);
      check(a0 == 24'd2 && w0 == bpat(1, 0) && r0 == 16'h0, "R7 first record",
            {a0, w0, r0}, {24'd2, bpat(1, 0), 16'h0});
      err_hold = 1'b0;
      wait_done(ok);
      check(err_seen == NCYC, "R9 continues after errors", err_seen, NCYC);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule